// File: doc/BRIEF.md
# Fractional-N Dual-Modulus Clock Divider

This block divides a fast input clock by a ratio that is N+F on average. N is an integer of at least 2. F is an unsigned binary fraction, held as a word `divFrac` and read as `divFrac / 2^FRAC_W`. Each division cycle counts either N or N+1 input clocks. An overflow accumulator picks the count: once per division cycle it adds the fraction word to a running sum. When that sum wraps past one, the cycle that follows is one input clock longer. The long cycles are spread over time, so that a share F of all cycles is long.

The block sits in front of the phase comparator of a fractional-N synthesizer loop. It gives three outputs. `divPulse` is a one-clock strobe at the end of every division cycle. `divClk` is a registered clock with close to 50% duty. `modSel` is the modulus selector of the cycle that is running. `divInt` and `divFrac` are only taken at cycle boundaries. The control software can therefore change them at any time without cutting a cycle short or stretching it.

Top module: `fracn_divider`

## Requirements
- R1: At the last input clock of each division cycle, the accumulator adds `divFrac` to its sum modulo 2^FRAC_W. The next cycle's selector `modSel` is 1 exactly when that addition reached or passed 2^FRAC_W, and 0 otherwise.
- R2: A division cycle whose `modSel` is 0 lasts `divInt` input clocks, and one whose `modSel` is 1 lasts `divInt`+1. `modSel` changes only on the clock edge that starts a new cycle.
- R3: Starting from a cleared accumulator, the 2^FRAC_W cycles that follow the first cycle contain exactly `divFrac` long cycles. Their total length is 2^FRAC_W·`divInt` + `divFrac` input clocks.
- R4: `divPulse` is high for exactly one input clock, directly after the edge that ends each division cycle, and is low at all other times.
- R5: `divClk` is high for the first floor(m/2) input clocks of each division cycle of length m and low for the rest. The clock on which `divPulse` is high is the first clock of the new cycle.
- R6: `divInt` and `divFrac` are sampled only on the edge that ends a cycle. A change in the middle of a cycle leaves that cycle's length alone and takes effect from the next accumulation and the next cycle.
- R7: While `rstN` is low, `divPulse`, `divClk` and `modSel` are 0 and the accumulator is cleared. The first edge after release samples `divInt`. The first cycle uses modulus `divInt`, so that the first `divPulse` follows the (`divInt`+1)-th edge after release.
- R8: `divInt` is at least 2 whenever it is sampled.
- R9: When `divInt` changes on the same boundary edge at which the accumulator wraps, the next cycle lasts new `divInt` + 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast input clock to be divided |
| rstN | input | 1 | Active-low synchronous reset |
| divInt | input | INT_W | Integer part N of the division ratio, at least 2 |
| divFrac | input | FRAC_W | Fractional part F, scaled by 2^FRAC_W |
| divPulse | output | 1 | One-clock strobe at each cycle boundary |
| divClk | output | 1 | Registered divided clock, high for the first half of each cycle |
| modSel | output | 1 | 1 when the running cycle counts N+1 clocks |

## Verification
Two events can fall on the same boundary edge: the accumulator overflows, and the next integer modulus is sampled. If both are taken correctly, the cycle that follows uses the new integer plus one. The bench provokes this by changing `divInt` on the very last clock of a cycle, at a point where it knows that the next accumulation wraps. The bench then checks that the following interval is new N + 1 and that `modSel` is 1. A second case changes both inputs in the middle of a cycle. For that case the bench checks that the running interval keeps its old length, and that the accumulator's later carries follow from the new fraction alone.

// File: rtl/fracn_div_pkg.sv
package fracn_div_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // first edge after reset: take integer modulus, no accumulation
    logic wrap;   // last clock of a division cycle: accumulate and pick next modulus
  } divStrobe_t;

endpackage

// File: rtl/fracn_div_dp.sv
module fracn_div_dp
  import fracn_div_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  divStrobe_t        stb,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic [INT_W:0]    nextMod,
  output logic              modSel
);

  localparam int SUM_W = FRAC_W + 1;

  logic [FRAC_W-1:0] accReg;
  logic [SUM_W-1:0]  accSum;
  logic              overflow;

  assign accSum   = {1'b0, accReg} + {1'b0, divFrac};
  assign overflow = stb.wrap & accSum[FRAC_W];
  assign nextMod  = {1'b0, divInt} + {{INT_W{1'b0}}, overflow};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accReg <= '0;
      modSel <= 1'b0;
    end else if (stb.wrap) begin
      accReg <= accSum[FRAC_W-1:0];
      modSel <= overflow;
    end else if (stb.load) begin
      modSel <= 1'b0;
    end
  end

  // R1
  acc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.wrap |=> $stable(accReg));

  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.wrap && !stb.load) |=> $stable(modSel));

  // R8
  min_int_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.wrap || stb.load) |-> (divInt >= INT_W'(2)));

endmodule

// File: rtl/fracn_div_ctrl.sv
module fracn_div_ctrl
  import fracn_div_pkg::*;
#(
  parameter int INT_W = 8
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic [INT_W:0] nextMod,
  output divStrobe_t     stb,
  output logic           divPulse,
  output logic           divClk
);

  localparam int CNT_W = INT_W + 1;

  logic             primed;
  logic [CNT_W-1:0] cnt, curMod;
  logic [CNT_W-1:0] cntNext, modNext;
  logic             lastCount;

  assign lastCount = primed && (cnt == curMod - CNT_W'(1));
  assign stb.load  = !primed;
  assign stb.wrap  = lastCount;

  always_comb begin
    if (stb.load || stb.wrap) begin
      cntNext = '0;
      modNext = nextMod;
    end else begin
      cntNext = cnt + CNT_W'(1);
      modNext = curMod;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      primed   <= 1'b0;
      cnt      <= '0;
      curMod   <= '0;
      divPulse <= 1'b0;
      divClk   <= 1'b0;
    end else begin
      primed   <= 1'b1;
      cnt      <= cntNext;
      curMod   <= modNext;
      divPulse <= lastCount;
      divClk   <= (cntNext < (modNext >> 1));
    end
  end

  // R4
  pulse_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    divPulse |=> !divPulse);

  // R2
  count_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    primed |-> (cnt < curMod));

  // R6
  mod_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (primed && !lastCount) |=> $stable(curMod));

endmodule

// File: rtl/fracn_divider.sv
module fracn_divider
  import fracn_div_pkg::*;
#(
  parameter int INT_W  = 8,
  parameter int FRAC_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  output logic              divPulse,
  output logic              divClk,
  output logic              modSel
);

  divStrobe_t     stb;
  logic [INT_W:0] nextMod;

  fracn_div_ctrl #(.INT_W(INT_W)) ctrl (
    .clk(clk), .rstN(rstN), .nextMod(nextMod),
    .stb(stb), .divPulse(divPulse), .divClk(divClk)
  );

  fracn_div_dp #(.INT_W(INT_W), .FRAC_W(FRAC_W)) dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .divInt(divInt), .divFrac(divFrac),
    .nextMod(nextMod), .modSel(modSel)
  );

endmodule

// File: tb/fracn_divider_test.sv
module fracn_divider_test;

  localparam int IW   = 8;
  localparam int FW   = 8;
  localparam int SPAN = 1 << FW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [IW-1:0] divInt = IW'(2);
  logic [FW-1:0] divFrac = '0;
  logic          divPulse, divClk, modSel;

  int testsRun = 0;
  int testsFailed = 0;

  always #5 clk = ~clk;

  fracn_divider #(.INT_W(IW), .FRAC_W(FW)) uut (
    .clk(clk), .rstN(rstN), .divInt(divInt), .divFrac(divFrac),
    .divPulse(divPulse), .divClk(divClk), .modSel(modSel)
  );

  task automatic check(input bit ok, input string what, input int act, input int exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: actual %0d expected %0d", what, act, exp);
    end
  endtask

  task automatic applyReset(input int n, input int f);
    @(negedge clk);
    rstN = 1'b0;
    divInt = IW'(n);
    divFrac = FW'(f);
    repeat (3) @(negedge clk);
    // R7 outputs idle in reset
    check(!divPulse && !divClk && !modSel, "R7 outputs low in reset",
          {29'd0, divPulse, divClk, modSel}, 0);
    rstN = 1'b1;
  endtask

  // steps from the current sample to the next pulse sample, returns steps
  task automatic measure(output int len);
    len = 0;
    do begin
      @(negedge clk);
      len++;
    end while (!divPulse && len < 1000);
  endtask

  task automatic runSweep(input int n, input int f);
    int len, ce, m, c;
    int total = 0, longCnt = 0, errCar = 0, errLen = 0, errDuty = 0;
    applyReset(n, f);
    measure(len);
    // R7 first cycle uses N
    check(len == n + 1, $sformatf("R7 first pulse delay N=%0d", n), len, n + 1);
    for (int j = 1; j <= SPAN; j++) begin
      c  = int'(modSel);
      ce = (j * f) / SPAN - ((j - 1) * f) / SPAN;
      m  = n + ce;
      if (c != ce) errCar++;
      longCnt += c;
      len = 0;
      do begin
        if (divClk !== (len < m / 2)) errDuty++;
        @(negedge clk);
        len++;
      end while (!divPulse && len < 1000);
      if (len != m) errLen++;
      total += len;
    end
    check(errCar == 0, $sformatf("R1 carry sequence N=%0d F=%0d", n, f), errCar, 0);
    check(errLen == 0, $sformatf("R2 R4 cycle lengths N=%0d F=%0d", n, f), errLen, 0);
    check(errDuty == 0, $sformatf("R5 duty shape N=%0d F=%0d", n, f), errDuty, 0);
    check(longCnt == f, $sformatf("R3 long cycle count N=%0d", n), longCnt, f);
    check(total == SPAN * n + f, $sformatf("R3 total clocks N=%0d F=%0d", n, f),
          total, SPAN * n + f);
  endtask

  initial begin
    int len, rest;
    runSweep(2, 0);
    runSweep(3, 77);
    runSweep(10, 77);
    runSweep(5, 128);
    runSweep(2, 255);
    runSweep(7, 1);

    // R6 mid-cycle change of both inputs
    applyReset(4, 0);
    measure(len);
    @(negedge clk);
    divInt = IW'(7);
    divFrac = FW'(255);
    measure(rest);
    check(1 + rest == 4, "R6 running cycle keeps old length", 1 + rest, 4);
    check(modSel == 1'b0, "R6 first accumulation of new F no carry", int'(modSel), 0);
    measure(len);
    check(len == 7, "R6 new N applies next cycle", len, 7);
    check(modSel == 1'b1, "R1 second accumulation wraps", int'(modSel), 1);
    measure(len);
    check(len == 8, "R2 long cycle after wrap", len, 8);

    // R9 N change coincides with accumulator wrap
    applyReset(3, 128);
    measure(len);
    repeat (2) @(negedge clk);
    divInt = IW'(6);
    measure(rest);
    check(2 + rest == 3, "R9 running cycle keeps N=3", 2 + rest, 3);
    check(modSel == 1'b1, "R9 wrap on boundary", int'(modSel), 1);
    measure(len);
    check(len == 7, "R9 new N plus carry", len, 7);
    measure(len);
    check(len == 6, "R9 following short cycle", len, 6);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule